// File: doc/BRIEF.md
# Sleep Mode Control Unit

This unit sits beside a small processor core and decides which clock domains stay alive when the core executes its sleep instruction. It watches an 8-bit control byte from which it decodes a sleep-enable flag and a two-bit mode code. A sleep strobe from the core puts the unit to sleep only when the enable flag is set at that moment; otherwise the instruction does nothing. Depending on the mode, the unit drops the enables of the CPU, flash, I/O and asynchronous clock domains.

An enabled interrupt request wakes the unit. From the light (idle) mode, the core is then held for a fixed four-cycle halt. From the deep modes (power-down and standby), the unit first waits for the start-up timer's ready flag and then applies the same halt. When the core is released, a one-cycle pulse tells it to go. A companion flag selects between the reset vector and resuming after the sleep instruction. A reset at any time, during sleep included, returns every domain to running and raises the pulse with the reset-vector flag.

All control pins are plain levels or single-cycle strobes. There is no data stream, so there is no valid/ready handshake.

Top module: `sleep_ctrl`

## Requirements
- R1: Only three bits of `ctrl_byte` are decoded: bit 5 is sleep enable, bit 6 is the high mode bit and bit 4 is the low mode bit. All other bits have no effect.
- R2: A `sleep_op` strobe while running with bit 5 clear is a no-op: every clock enable stays high.
- R3: A `sleep_op` strobe while running with bit 5 set drops `cpu_clk_en` and `flash_clk_en` from the next cycle on.
- R4: Mode code 00 (idle) holds `cpu_clk_en` and `flash_clk_en` low while `io_clk_en` and `async_clk_en` stay high.
- R5: Mode codes 01 and 11 (power-down) hold all four clock enables low.
- R6: Mode code 10 (standby) holds the CPU, flash and I/O enables low and keeps `async_clk_en` high.
- R7: In idle, `irq_pending` high at a clock edge starts a halt of exactly 4 cycles. During the halt only `io_clk_en` and `async_clk_en` are high. `start_ready` has no effect on this path.
- R8: In a deep mode, `irq_pending` moves the unit to a wait in which only `async_clk_en` is high. The 4-cycle halt begins at the first edge after that with `start_ready` high.
- R9: The cycle after the last halt cycle, all enables are high and `cpu_go` is high for one cycle with `go_reset` low (resume after the sleep instruction).
- R10: While `rst_n` is low and for the first cycle after it rises, all enables are high and `cpu_go` and `go_reset` are both high (reset vector). This holds also when reset arrives during sleep.
- R11: `irq_pending` while running has no effect. A `sleep_op` while asleep, waiting or halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_byte | input | 8 | Control register contents (bit 6 mode hi, bit 5 enable, bit 4 mode lo) |
| sleep_op | input | 1 | One-cycle strobe: sleep instruction executed |
| irq_pending | input | 1 | An enabled interrupt is requesting service |
| start_ready | input | 1 | Start-up timer reports a stable oscillator |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| flash_clk_en | output | 1 | Flash clock domain enable |
| io_clk_en | output | 1 | I/O clock domain enable |
| async_clk_en | output | 1 | Asynchronous domain enable |
| cpu_go | output | 1 | One-cycle pulse releasing the core |
| go_reset | output | 1 | With `cpu_go`: 1 selects the reset vector, 0 resumes |

## Verification
All outputs are decoded from registered state. A strobe or request sampled at one rising edge therefore shows up in the cycle that starts there. The enables change one cycle after `sleep_op`, the halt fills the four cycles after the waking edge, and `cpu_go` appears in the fifth. The bench keeps a behavioural model that advances on the same edge and compares every output on each falling edge. This keeps the one-cycle latency and the exact halt length under check in every cycle, not only at chosen points.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_NAP,
    ST_DEEP,
    ST_WAKE,
    ST_HALT
  } slp_state_t;

  typedef enum logic [1:0] {
    MD_IDLE,
    MD_PDOWN,
    MD_STBY
  } slp_mode_t;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic asy;
  } clk_en_t;
endpackage

// File: rtl/sleep_mode_dec.sv
module sleep_mode_dec
  import sleep_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int SE_BIT = 5,
  parameter int M1_BIT = 6,
  parameter int M0_BIT = 4
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic              armed,
  output slp_mode_t         mode
);
  logic [1:0] code;

  assign armed = ctrl[SE_BIT];
  assign code  = {ctrl[M1_BIT], ctrl[M0_BIT]};

  always_comb begin
    case (code)
      2'b00:   mode = MD_IDLE;
      2'b10:   mode = MD_STBY;
      default: mode = MD_PDOWN;  // 01 and 11 alias
    endcase
  end
endmodule

// File: rtl/sleep_halt_timer.sv
module sleep_halt_timer #(
  parameter int HALT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(HALT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST_V) cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == LAST_V);
endmodule

// File: rtl/sleep_clk_dec.sv
module sleep_clk_dec
  import sleep_pkg::*;
(
  input  slp_state_t state,
  input  logic       standby,
  output clk_en_t    en
);
  always_comb begin
    case (state)
      ST_RUN:  en = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, asy: 1'b1};
      ST_NAP:  en = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, asy: 1'b1};
      ST_DEEP: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, asy: standby};
      ST_WAKE: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, asy: 1'b1};
      ST_HALT: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, asy: 1'b1};
      default: en = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, asy: 1'b1};
    endcase
  end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int SE_BIT   = 5,
  parameter int M1_BIT   = 6,
  parameter int M0_BIT   = 4,
  parameter int HALT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_byte,
  input  logic              sleep_op,
  input  logic              irq_pending,
  input  logic              start_ready,
  output logic              cpu_clk_en,
  output logic              flash_clk_en,
  output logic              io_clk_en,
  output logic              async_clk_en,
  output logic              cpu_go,
  output logic              go_reset
);
  slp_state_t st;
  slp_mode_t  mode;
  logic       armed, stby, halt_last;
  clk_en_t    en;

  sleep_mode_dec #(
    .CTRL_W(CTRL_W), .SE_BIT(SE_BIT), .M1_BIT(M1_BIT), .M0_BIT(M0_BIT)
  ) u_dec (
    .ctrl(ctrl_byte), .armed(armed), .mode(mode)
  );

  sleep_halt_timer #(.HALT_CYC(HALT_CYC)) u_halt (
    .clk(clk), .rst_n(rst_n), .run(st == ST_HALT), .last(halt_last)
  );

  sleep_clk_dec u_en (.state(st), .standby(stby), .en(en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      stby     <= 1'b0;
      cpu_go   <= 1'b1;
      go_reset <= 1'b1;
    end else begin
      cpu_go   <= 1'b0;
      go_reset <= 1'b0;
      case (st)
        ST_RUN:
          if (sleep_op && armed) begin
            if (mode == MD_IDLE) st <= ST_NAP;
            else begin
              st   <= ST_DEEP;
              stby <= (mode == MD_STBY);
            end
          end
        ST_NAP:  if (irq_pending) st <= ST_HALT;
        ST_DEEP: if (irq_pending) st <= ST_WAKE;
        ST_WAKE: if (start_ready) st <= ST_HALT;
        ST_HALT:
          if (halt_last) begin
            st     <= ST_RUN;
            cpu_go <= 1'b1;
          end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign cpu_clk_en   = en.cpu;
  assign flash_clk_en = en.flash;
  assign io_clk_en    = en.io;
  assign async_clk_en = en.asy;
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
  parameter int CTRL_W = 8,
  parameter int SE_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_byte,
  input logic              sleep_op,
  input logic              irq_pending,
  input logic              start_ready,
  input logic              cpu_clk_en,
  input logic              flash_clk_en,
  input logic              io_clk_en,
  input logic              async_clk_en,
  input logic              cpu_go,
  input logic              go_reset
);
  a_r2_noop_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_op && !ctrl_byte[SE_BIT]) |=> cpu_clk_en);

  a_r3_enter_drops_core: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_op && ctrl_byte[SE_BIT]) |=> (!cpu_clk_en && !flash_clk_en));

  a_r11_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !sleep_op) |=> cpu_clk_en);

  a_r5_io_off_core_off: assert property (@(posedge clk) disable iff (!rst_n)
    !io_clk_en |-> (!cpu_clk_en && !flash_clk_en));

  a_r8_ready_before_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && $rose(io_clk_en)) |-> $past(start_ready));

  a_r9_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |=> !cpu_go);

  a_r9_go_running: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |-> (cpu_clk_en && io_clk_en && async_clk_en));

  a_r10_vec_with_go: assert property (@(posedge clk) disable iff (!rst_n)
    go_reset |-> cpu_go);
endmodule

bind sleep_ctrl sleep_ctrl_chk #(.CTRL_W(CTRL_W), .SE_BIT(SE_BIT)) u_chk (.*);

// File: tb/sleep_ctrl_test.sv
module sleep_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ctrl_byte;
  logic       sleep_op, irq_pending, start_ready;
  logic       cpu_clk_en, flash_clk_en, io_clk_en, async_clk_en, cpu_go, go_reset;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;
  string scen = "R10 reset";

  // model state: 0 run, 1 idle, 2 deep, 3 wait ready, 4 halt
  int m_st = 0;
  int m_cnt = 0;
  bit m_stby = 0;
  bit m_go = 1;
  bit m_gor = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .sleep_op(sleep_op),
    .irq_pending(irq_pending), .start_ready(start_ready),
    .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
    .async_clk_en(async_clk_en), .cpu_go(cpu_go), .go_reset(go_reset)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_stby <= 0; m_go <= 1; m_gor <= 1;
    end else begin
      m_go <= 0; m_gor <= 0;
      case (m_st)
        0: if (sleep_op && ctrl_byte[5]) begin
             if (!ctrl_byte[6] && !ctrl_byte[4]) m_st <= 1;
             else begin m_st <= 2; m_stby <= ctrl_byte[6] && !ctrl_byte[4]; end
           end
        1: if (irq_pending) begin m_st <= 4; m_cnt <= 0; end
        2: if (irq_pending) m_st <= 3;
        3: if (start_ready) begin m_st <= 4; m_cnt <= 0; end
        default: if (m_cnt == HALT - 1) begin m_st <= 0; m_go <= 1; end
                 else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  function automatic string st_tag(int s, bit sb);
    case (s)
      0: return "R3";
      1: return "R4";
      2: return sb ? "R6" : "R5";
      3: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string what, logic got, logic exp, string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s [%s] %s: got=%0b exp=%0b at cycle %0d", req, scen, what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      string t;
      string g;
      t = st_tag(m_st, m_stby);
      g = m_gor ? "R10" : "R9";
      chk("cpu_clk_en",   cpu_clk_en,   m_st == 0, t);
      chk("flash_clk_en", flash_clk_en, m_st == 0, t);
      chk("io_clk_en",    io_clk_en,    m_st == 0 || m_st == 1 || m_st == 4, t);
      chk("async_clk_en", async_clk_en, !(m_st == 2 && !m_stby), t);
      chk("cpu_go",       cpu_go,       m_go, g);
      chk("go_reset",     go_reset,     m_gor, g);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_sleep(logic [7:0] cb);
    ctrl_byte = cb;
    sleep_op = 1'b1;
    wait_cyc(1);
    sleep_op = 1'b0;
    ctrl_byte = 8'h00;  // clear enable right after, as firmware would
  endtask

  task automatic pulse_irq();
    irq_pending = 1'b1;
    wait_cyc(1);
    irq_pending = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ctrl_byte = 8'h00; sleep_op = 0; irq_pending = 0; start_ready = 0;
    @(posedge clk);
    @(negedge clk);
    started = 1;          // R10: outputs checked while reset is held
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(3);

    scen = "R2 noop sleep";
    do_sleep(8'h00);
    wait_cyc(3);

    scen = "R1 other bits ignored";
    do_sleep(8'h8F);
    wait_cyc(3);
    ctrl_byte = 8'hDF;   // R1: all bits but enable set, no strobe
    wait_cyc(2);
    ctrl_byte = 8'h00;

    scen = "R11 irq while running";
    irq_pending = 1'b1;
    wait_cyc(4);
    irq_pending = 1'b0;

    scen = "R4 R7 idle wake";
    start_ready = 1'b1;  // ignored on the idle path
    do_sleep(8'h20);
    wait_cyc(3);
    scen = "R11 sleep while asleep";
    do_sleep(8'h30);
    wait_cyc(1);
    scen = "R7 R9 idle halt";
    pulse_irq();
    wait_cyc(8);

    scen = "R5 R8 power-down 01";
    start_ready = 1'b0;
    do_sleep(8'h30);
    wait_cyc(3);
    pulse_irq();
    wait_cyc(4);         // waiting on start-up
    start_ready = 1'b1;
    wait_cyc(1);
    start_ready = 1'b0;
    wait_cyc(8);

    scen = "R5 R1 power-down 11";
    start_ready = 1'b1;
    do_sleep(8'hF0);
    wait_cyc(3);
    pulse_irq();
    wait_cyc(8);

    scen = "R6 standby";
    start_ready = 1'b0;
    do_sleep(8'h60);
    wait_cyc(4);
    irq_pending = 1'b1;
    start_ready = 1'b1;
    wait_cyc(1);
    irq_pending = 1'b0;
    wait_cyc(8);

    scen = "R10 reset in sleep";
    start_ready = 1'b0;
    do_sleep(8'h30);
    wait_cyc(3);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(4);

    scen = "R10 reset in halt";
    do_sleep(8'h20);
    wait_cyc(2);
    pulse_irq();
    wait_cyc(1);
    rst_n = 1'b0;
    wait_cyc(1);
    rst_n = 1'b1;
    wait_cyc(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule